// File: doc/BRIEF.md
# Zero-Cross Fade Mute Controller

This block scales a stream of signed 24-bit audio samples by a gain that moves between full level and silence. The gain follows a smooth S-shaped curve, so muting and unmuting do not cause audible clicks. The curve is a fixed table of `STEPS + 1` levels. Index 0 is silence and index `STEPS` is unity gain.

The controller moves the index by one step only when the signal crosses zero. At that moment the amplitude is small, so a gain change adds almost no discontinuity. If the signal stays on one side of zero for too long during a fade, the controller stops waiting and steps once per sample until the fade ends.

A mute request selects the direction of the fade. An abort input silences the output at once and returns the index to silence. After the abort is released, a fade-in starts again from mute. A one-cycle done pulse marks each sample on which a fade reaches either end.

Top module: `zc_fade_mute`

## Requirements
- R1: After reset, the index is at full level (`STEPS`), and `outValid`, `outData` and `fadeDone` are 0. The first sample is passed through unchanged.
- R2: `outValid` goes high exactly one clock after a cycle with `inValid` high, and is low otherwise.
- R3: The gain at index i is round(32768·(3·i²·STEPS − 2·i³)/STEPS³) with `GAIN_W`=16. The output is input·gain/32768, truncated toward zero. It is computed with the index that holds after this sample's step.
- R4: A sample is a zero crossing when it equals 0, or when its sign bit differs from the sign bit of the previous accepted sample. A zero sample counts as non-negative. The first sample after reset or after abort has no previous sample.
- R5: While `muteReq` is 1 and the index is above 0, each zero-crossing sample lowers the index by one. No step occurs on any other sample unless the timeout is active.
- R6: While `muteReq` is 0 and the index is below `STEPS`, each zero-crossing sample raises the index by one.
- R7: After `TIMEOUT` consecutive fading samples with no crossing, every later sample steps the index until the fade reaches its end.
- R8: A change of `muteReq` in the middle of a fade reverses the direction, starting from the current index.
- R9: The clock after `abortReq` is seen high, `outData` is 0 and the index is 0. While abort is held, samples produce 0 and the sign history is cleared. After release, the index rises again from mute.
- R10: `fadeDone` is high for one clock, together with `outValid`, for the sample whose step brings the index to 0 or to `STEPS`.
- R11: In cycles with no valid sample, the index does not change, whatever `muteReq` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input sample strobe |
| inData | input | DATA_W | Signed input sample |
| muteReq | input | 1 | 1 selects fade to silence, 0 selects fade to full level |
| abortReq | input | 1 | Force silence and return the index to mute |
| outValid | output | 1 | Output sample strobe |
| outData | output | DATA_W | Signed scaled sample |
| fadeDone | output | 1 | Pulse on the sample that completes a fade |

## Verification
The bench builds the block with the default 24-bit samples, 16-bit gain and 48 steps, and lowers `TIMEOUT` to 16. With that timeout, the forced-stepping fallback appears after sixteen quiet samples instead of thousands. A full 48-step fade-out under timeout, followed by a full fade-in, fits into a few hundred cycles. Inputs of 2^22 turn the output into an exact multiple of the gain, so the bench can observe the current index at the ports.

// File: rtl/fade_pkg.sv
package fade_pkg;

  // Strobes passed from the control module to the datapath each cycle.
  typedef struct packed {
    logic sampleEn;   // a sample is being processed this cycle
    logic forceZero;  // abort: clear the output
    logic doneHit;    // this sample's step completes a fade
  } fadeStrobes_t;

  // Smoothstep level 3t^2 - 2t^3 scaled to the unity gain 2^(gainW-1), rounded.
  function automatic longint sCurveGain(input int idx, input int steps, input int gainW);
    longint li, ls, unity, num, den;
    li    = longint'(idx);
    ls    = longint'(steps);
    unity = longint'(1) << (gainW - 1);
    num   = 3 * li * li * ls - 2 * li * li * li;
    den   = ls * ls * ls;
    return (unity * num + den / 2) / den;
  endfunction

endpackage

// File: rtl/fade_ctrl.sv
module fade_ctrl #(
  parameter int DATA_W  = 24,
  parameter int STEPS   = 48,
  parameter int TIMEOUT = 8192,
  parameter int IDX_W   = $clog2(STEPS + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic [DATA_W-1:0]        inData,
  input  logic                     muteReq,
  input  logic                     abortReq,
  output fade_pkg::fadeStrobes_t   strobes,
  output logic [IDX_W-1:0]         nextIdx,
  output logic [IDX_W-1:0]         curIdx
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [IDX_W-1:0] FULL_IDX = IDX_W'(STEPS);
  localparam logic [CNT_W-1:0] QUIET_LAST = CNT_W'(TIMEOUT - 1);

  logic             havePrev;
  logic             prevSign;
  logic [CNT_W-1:0] quietCnt;
  logic             forced;

  logic             crossing;
  logic [IDX_W-1:0] targetIdx;
  logic             fading;
  logic             stepNow;

  always_comb begin
    crossing  = (inData == '0) || (havePrev && (inData[DATA_W-1] != prevSign));
    targetIdx = muteReq ? '0 : FULL_IDX;
    fading    = (curIdx != targetIdx);
    stepNow   = inValid && !abortReq && fading && (crossing || forced);

    nextIdx = curIdx;
    if (abortReq)
      nextIdx = '0;
    else if (stepNow)
      nextIdx = (targetIdx > curIdx) ? curIdx + 1'b1 : curIdx - 1'b1;

    strobes.sampleEn  = inValid;
    strobes.forceZero = abortReq;
    strobes.doneHit   = stepNow && ((nextIdx == '0) || (nextIdx == FULL_IDX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curIdx   <= FULL_IDX;
      havePrev <= 1'b0;
      prevSign <= 1'b0;
      quietCnt <= '0;
      forced   <= 1'b0;
    end else begin
      curIdx <= nextIdx;
      if (abortReq) begin
        havePrev <= 1'b0;
        quietCnt <= '0;
        forced   <= 1'b0;
      end else begin
        if (inValid) begin
          havePrev <= 1'b1;
          prevSign <= inData[DATA_W-1];
        end
        if (!fading) begin
          quietCnt <= '0;
          forced   <= 1'b0;
        end else if (stepNow) begin
          quietCnt <= '0;
        end else if (inValid) begin
          if (quietCnt == QUIET_LAST)
            forced <= 1'b1;
          else
            quietCnt <= quietCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fade_datapath.sv
module fade_datapath #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 16,
  parameter int STEPS  = 48,
  parameter int IDX_W  = $clog2(STEPS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  fade_pkg::fadeStrobes_t  strobes,
  input  logic [IDX_W-1:0]        gainIdx,
  input  logic [DATA_W-1:0]       inData,
  output logic                    outValid,
  output logic [DATA_W-1:0]       outData,
  output logic                    fadeDone
);
  localparam int PROD_W = DATA_W + GAIN_W + 1;
  localparam int SH     = GAIN_W - 1;

  logic [GAIN_W-1:0] gainTab [STEPS+1];

  for (genvar g = 0; g <= STEPS; g++) begin : gen_gain
    assign gainTab[g] = GAIN_W'(fade_pkg::sCurveGain(g, STEPS, GAIN_W));
  end

  logic [GAIN_W-1:0]        selGain;
  logic signed [PROD_W-1:0] dataExt;
  logic signed [PROD_W-1:0] gainExt;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] roundAdd;
  logic signed [PROD_W-1:0] biased;
  logic [DATA_W-1:0]        scaled;

  always_comb begin
    selGain  = gainTab[gainIdx];
    dataExt  = PROD_W'($signed(inData));
    gainExt  = $signed(PROD_W'(selGain));
    prod     = dataExt * gainExt;
    roundAdd = prod[PROD_W-1] ? $signed(PROD_W'((longint'(1) << SH) - 1)) : '0;
    biased   = prod + roundAdd;
    scaled   = DATA_W'(biased >>> SH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= '0;
      fadeDone <= 1'b0;
    end else begin
      outValid <= strobes.sampleEn;
      fadeDone <= strobes.doneHit;
      if (strobes.forceZero)
        outData <= '0;
      else if (strobes.sampleEn)
        outData <= scaled;
    end
  end

endmodule

// File: rtl/zc_fade_mute.sv
module zc_fade_mute #(
  parameter int DATA_W  = 24,
  parameter int GAIN_W  = 16,
  parameter int STEPS   = 48,
  parameter int TIMEOUT = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              muteReq,
  input  logic              abortReq,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              fadeDone
);
  localparam int IDX_W = $clog2(STEPS + 1);

  fade_pkg::fadeStrobes_t strobes;
  logic [IDX_W-1:0]       nextIdx;
  logic [IDX_W-1:0]       curIdx;

  fade_ctrl #(
    .DATA_W(DATA_W), .STEPS(STEPS), .TIMEOUT(TIMEOUT), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .muteReq(muteReq), .abortReq(abortReq),
    .strobes(strobes), .nextIdx(nextIdx), .curIdx(curIdx)
  );

  fade_datapath #(
    .DATA_W(DATA_W), .GAIN_W(GAIN_W), .STEPS(STEPS), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .gainIdx(nextIdx), .inData(inData),
    .outValid(outValid), .outData(outData), .fadeDone(fadeDone)
  );

endmodule

// File: rtl/zc_fade_mute_checker.sv
module zc_fade_mute_checker #(
  parameter int DATA_W = 24,
  parameter int STEPS  = 48,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              abortReq,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              fadeDone,
  input logic [IDX_W-1:0]  curIdx
);
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(curIdx) <= STEPS); // R3
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    !abortReq |=> (int'(curIdx) <= int'($past(curIdx)) + 1) && (int'(curIdx) + 1 >= int'($past(curIdx)))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!inValid && !abortReq) |=> $stable(curIdx)); // R11
  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R2
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R2
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (rst)
    abortReq |=> (outData == '0) && (curIdx == '0)); // R9
  AST_DONE_WITH_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    fadeDone |-> outValid); // R10
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    fadeDone |-> (curIdx == '0) || (int'(curIdx) == STEPS)); // R10
endmodule

bind zc_fade_mute zc_fade_mute_checker #(
  .DATA_W(DATA_W), .STEPS(STEPS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .abortReq(abortReq),
  .outValid(outValid), .outData(outData), .fadeDone(fadeDone), .curIdx(curIdx)
);

// File: tb/zc_fade_mute_bench.sv
module zc_fade_mute_bench;
  localparam int DW = 24;
  localparam int NSTEPS = 48;
  localparam int TO = 16;
  localparam int BIG = 4194304;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic muteReq = 1'b0;
  logic abortReq = 1'b0;
  logic outValid;
  logic [DW-1:0] outData;
  logic fadeDone;

  always #2 clk = ~clk;

  zc_fade_mute #(.TIMEOUT(TO)) u_zc_fade_mute (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .muteReq(muteReq), .abortReq(abortReq),
    .outValid(outValid), .outData(outData), .fadeDone(fadeDone)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint gainOf(input int i);
    longint n, d;
    n = 3 * longint'(i) * i * NSTEPS - 2 * longint'(i) * i * i;
    d = longint'(NSTEPS) * NSTEPS * NSTEPS;
    return (32768 * n + d / 2) / d;
  endfunction

  function automatic longint scaleRef(input longint d, input int i);
    return (d * gainOf(i)) / 32768;
  endfunction

  // Drive one sample; return the output registered from it.
  task automatic send(input longint d, output longint got, output logic gotDone);
    @(negedge clk);
    inValid = 1'b1;
    inData  = DW'(d);
    @(negedge clk);
    inValid = 1'b0;
    got     = longint'($signed(outData));
    gotDone = fadeDone;
    check("R2 outValid after sample", longint'(outValid), 1);
  endtask

  typedef struct packed {
    logic mute;
    logic signed [DW-1:0] data;
    logic [5:0] idx;
    logic done;
  } vec_t;

  localparam int VEC_N = 12;
  localparam vec_t VECS [VEC_N] = '{
    '{1'b0,  24'sd1000, 6'd48, 1'b0},
    '{1'b1,  24'sd1000, 6'd48, 1'b0},
    '{1'b1, -24'sd500,  6'd47, 1'b0},
    '{1'b1, -24'sd700,  6'd47, 1'b0},
    '{1'b1,  24'sd0,    6'd46, 1'b0},
    '{1'b1,  24'sd300,  6'd46, 1'b0},
    '{1'b1, -24'sd300,  6'd45, 1'b0},
    '{1'b0,  24'sd200,  6'd46, 1'b0},
    '{1'b0,  24'sd250,  6'd46, 1'b0},
    '{1'b0, -24'sd1,    6'd47, 1'b0},
    '{1'b0,  24'sd0,    6'd48, 1'b1},
    '{1'b0,  24'sd5,    6'd48, 1'b0}
  };

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    longint got;
    logic gd;
    longint held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset outValid", longint'(outValid), 0);
    check("R1 reset outData", longint'(outData), 0);
    check("R1 reset fadeDone", longint'(fadeDone), 0);
    send(1234, got, gd);
    check("R1 unity after reset", got, 1234);
    @(negedge clk);
    check("R2 outValid drops", longint'(outValid), 0);

    // R4 R5 R6 R8 R3: vector walk
    for (int v = 0; v < VEC_N; v++) begin
      muteReq = VECS[v].mute;
      send(longint'(VECS[v].data), got, gd);
      check($sformatf("R3/R4/R5/R6/R8 vec %0d data", v), got,
            scaleRef(longint'(VECS[v].data), int'(VECS[v].idx)));
      check($sformatf("R10 vec %0d done", v), longint'(gd), longint'(VECS[v].done));
    end

    // R7: timeout, fade-out with no crossings
    muteReq = 1'b1;
    for (int k = 1; k <= 65; k++) begin
      int ei;
      ei = (k <= TO) ? NSTEPS : ((NSTEPS - (k - TO)) < 0 ? 0 : NSTEPS - (k - TO));
      send(BIG, got, gd);
      check($sformatf("R7 timeout sample %0d", k), got, gainOf(ei) * 128);
      check($sformatf("R10 timeout done %0d", k), longint'(gd), (k == TO + NSTEPS) ? 1 : 0);
    end

    // R6: fade-in with a crossing on every sample
    muteReq = 1'b0;
    for (int k = 1; k <= NSTEPS; k++) begin
      longint d;
      d = (k % 2 == 1) ? -BIG : BIG;
      send(d, got, gd);
      check($sformatf("R6 fade-in sample %0d", k), got, scaleRef(d, k));
      check($sformatf("R10 fade-in done %0d", k), longint'(gd), (k == NSTEPS) ? 1 : 0);
    end

    // R11: mute request toggles with no samples; index must hold
    held = longint'($signed(outData));
    muteReq = 1'b1;
    repeat (6) @(negedge clk);
    check("R11 output held while idle", longint'($signed(outData)), held);
    send(BIG, got, gd);
    check("R11 no step while idle", got, BIG);
    muteReq = 1'b0;

    // R9: abort
    send(1000, got, gd);
    check("R9 pre-abort level", got, 1000);
    @(negedge clk);
    abortReq = 1'b1;
    @(negedge clk);
    check("R9 output cleared", longint'(outData), 0);
    send(5000, got, gd);
    check("R9 sample during abort", got, 0);
    @(negedge clk);
    abortReq = 1'b0;
    send(-2000, got, gd);
    check("R9 first after release at mute", got, 0);
    send(2000, got, gd);
    check("R9 fade-in restarts from mute", got, scaleRef(2000, 1));

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule